// File: doc/BRIEF.md
# Error-Correcting Word Store Controller with Partial-Write Merge

This controller sits between a simple 32-bit request/response port and a single-port synchronous SRAM that is 39 bits wide. Each SRAM word holds 32 data bits, six Hamming check bits and one overall parity bit. Together they form a single-error-correcting, double-error-detecting code computed over the whole 32-bit word. The port accepts byte, halfword and word writes and word reads. A write is not sent to the SRAM at once. It is parked in a one-entry posted write buffer, and that buffer is written to the SRAM only when a later request needs the SRAM or needs the buffer.

A byte or halfword write to a word that is not in the buffer first reads the stored word from the SRAM. The controller checks and corrects that word, replaces the written lanes, and places the result in the buffer. The check bits are then computed from the merged word when the buffer drains. A read to the buffered word is answered from the buffer. A read that misses is decoded: a single-bit error is corrected and flagged, and a double-bit error is flagged while the raw data bits are returned.

The control is a four-state machine:
- IDLE accepts requests. It answers rejects, buffer hits, and word writes into an empty buffer in place. Otherwise it moves to DRAIN when the buffer is full, or to FETCH when it is empty.
- DRAIN writes the buffered word to the SRAM. It then returns to IDLE for a word write, which loads the buffer in the same cycle, or moves on to FETCH.
- FETCH issues the SRAM read.
- CHECK decodes the returned word, then answers the read or merges the write into the buffer, and returns to IDLE.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: Every SRAM word written has data in bits [31:0] and Hamming bits in [37:32], with even parity over all 39 bits held in bit 38. Codeword positions 1..38 are numbered so that the powers of two (1,2,4,8,16,32) belong to Hamming bits 0..5. Data bits 0..31 take the remaining positions in rising order, starting with 3,5,6,7,9. Hamming bit k is the XOR of the data bits whose position has bit k set.
- R2: An accepted write never writes the SRAM itself. The buffered word is written to the SRAM only when a later accepted, non-rejected request to a different word arrives.
- R3: A read to the word held in the buffer returns the buffered data with both error flags low, and causes no SRAM access.
- R4: A write to the word held in the buffer merges its lanes into the buffer without any SRAM access.
- R5: A byte or halfword write to a word not in the buffer reads that word from the SRAM before anything is written for it. Lanes the write does not select keep their corrected stored value.
- R6: Lanes follow the address offset (bits [1:0]) and the size code (0 = byte, 1 = halfword, 2 = word). A byte write takes lane offset. A halfword write takes lanes offset and offset+1. A word write takes all four lanes. A read always returns the whole word, and its size and offset are ignored.
- R7: A write with size 3, a halfword write at an odd offset, or a word write at a nonzero offset is answered with the error flag set. It changes neither the buffer nor the SRAM.
- R8: A word with one flipped bit, in data, check or parity, is returned corrected with the correctable flag set.
- R9: A word with two flipped bits is answered with the uncorrectable flag set and its raw stored data bits.
- R10: A byte or halfword write whose pre-read finds two flipped bits is still performed on the raw data, and its response carries the uncorrectable flag.
- R11: Each accepted request gets exactly one response, and the ready output stays low while the SRAM is in use. The response follows the accepting edge by 0 cycles for a reject, a buffer hit, or a word write into an empty buffer. Any other request adds 1 cycle when the buffer must drain, and 2 more cycles unless it is a word write.
- R12: After reset the ready output is high, no response is pending, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, already placed in its byte lanes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Request rejected for size or alignment |
| rsp_corr | output | 1 | A single-bit error was corrected |
| rsp_uncorr | output | 1 | A double-bit error was detected |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W-2 | SRAM word address |
| mem_wdata | output | 39 | Codeword to store |
| mem_rdata | input | 39 | Codeword read, valid the cycle after a read strobe |

## Verification
The assertions assume that the SRAM returns read data exactly one cycle after a read strobe. They also assume that requests are only counted when valid and ready meet, which is why the ready-related checks are tied to the access strobe. The stimulus respects both assumptions. The bench's SRAM model answers with a one-cycle registered read. The bench raises one request at a time and holds it until ready is seen, then waits for the response before issuing the next. Bit flips are injected only into words that are not held in the write buffer, so the stored word is the one the decoder actually sees.

// File: rtl/ecc_ctrl_pkg.sv
package ecc_ctrl_pkg;
    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CODE_W = DATA_W + HAM_W + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_FETCH, ST_CHECK} ctrl_state_t;

    // Codeword position of data bit idx: the idx-th non-power-of-two in 1..CODE_W-1
    function automatic logic [HAM_W-1:0] data_pos(input int idx);
        logic [HAM_W-1:0] res;
        int seen;
        res  = '0;
        seen = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) res = HAM_W'(p);
                seen++;
            end
        end
        return res;
    endfunction

    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) h ^= data_pos(i);
        end
        return h;
    endfunction
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_ctrl_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [HAM_W-1:0] ham;

    assign ham    = ham_bits(data_i);
    assign code_o = {^{ham, data_i}, ham, data_i};
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_ctrl_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              uncorr_o
);
    logic [HAM_W-1:0]  syn;
    logic              par_err;
    logic              syn_pow2;
    logic [DATA_W-1:0] flip;

    assign syn      = ham_bits(code_i[DATA_W-1:0]) ^ code_i[DATA_W+HAM_W-1:DATA_W];
    assign par_err  = ^code_i;
    assign syn_pow2 = (syn & (syn - HAM_W'(1))) == '0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        assign flip[i] = par_err && (syn == data_pos(i));
    end

    assign corr_o   = par_err && (syn_pow2 || (|flip));
    assign uncorr_o = par_err ? !(syn_pow2 || (|flip)) : (syn != '0);
    assign data_o   = code_i[DATA_W-1:0] ^ flip;
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]         size_i,
    input  logic [OFF_W-1:0]   offs_i,
    input  logic [8*LANES-1:0] old_i,
    input  logic [8*LANES-1:0] new_i,
    output logic [8*LANES-1:0] merged_o,
    output logic               bad_o
);
    logic [OFF_W-1:0] low_mask;

    assign low_mask = OFF_W'((1 << size_i) - 1);
    assign bad_o    = (32'(size_i) > OFF_W) || ((offs_i & low_mask) != '0);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic sel;
        assign sel = ((OFF_W'(j) ^ offs_i) >> size_i) == '0;
        assign merged_o[8*j +: 8] = sel ? new_i[8*j +: 8] : old_i[8*j +: 8];
    end
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
    import ecc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_corr,
    output logic              rsp_uncorr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata
);
    ctrl_state_t state, state_nx;

    logic              op_write, op_full;
    logic [1:0]        op_size;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic              buf_valid;
    logic [ADDR_W-3:0] buf_addr;
    logic [DATA_W-1:0] buf_data;

    logic [DATA_W-1:0] dec_data, mg_old, mg_new, mg_data;
    logic              dec_corr, dec_uncorr, mg_bad;
    logic [1:0]        mg_size, mg_offs;
    logic              accept, req_hit, req_full, rej, in_idle;

    assign in_idle   = (state == ST_IDLE);
    assign req_ready = in_idle;
    assign accept    = req_valid && req_ready;
    assign req_hit   = buf_valid && (buf_addr == req_addr[ADDR_W-1:2]);
    assign req_full  = (req_size == 2'd2);
    assign rej       = req_write && mg_bad;

    assign mg_size = in_idle ? req_size : op_size;
    assign mg_offs = in_idle ? req_addr[1:0] : op_addr[1:0];
    assign mg_new  = in_idle ? req_wdata : op_wdata;
    assign mg_old  = (state == ST_CHECK) ? dec_data : buf_data;

    ecc_lane_merge #(.LANES(DATA_W / 8)) u_merge (
        .size_i(mg_size), .offs_i(mg_offs), .old_i(mg_old), .new_i(mg_new),
        .merged_o(mg_data), .bad_o(mg_bad)
    );

    ecc_secded_enc u_enc (.data_i(buf_data), .code_o(mem_wdata));

    ecc_secded_dec u_dec (
        .code_i(mem_rdata), .data_o(dec_data), .corr_o(dec_corr), .uncorr_o(dec_uncorr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && !rej && !req_hit && !(req_write && req_full && !buf_valid))
                    state_nx = buf_valid ? ST_DRAIN : ST_FETCH;
            end
            ST_DRAIN: state_nx = (op_write && op_full) ? ST_IDLE : ST_FETCH;
            ST_FETCH: state_nx = ST_CHECK;
            ST_CHECK: state_nx = ST_IDLE;
        endcase
    end

    assign mem_en   = (state == ST_DRAIN) || (state == ST_FETCH);
    assign mem_we   = (state == ST_DRAIN);
    assign mem_addr = (state == ST_DRAIN) ? buf_addr : op_addr[ADDR_W-1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write   <= 1'b0;
            op_full    <= 1'b0;
            op_size    <= '0;
            op_addr    <= '0;
            op_wdata   <= '0;
            buf_valid  <= 1'b0;
            buf_addr   <= '0;
            buf_data   <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_err    <= 1'b0;
            rsp_corr   <= 1'b0;
            rsp_uncorr <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_err    <= 1'b0;
            rsp_corr   <= 1'b0;
            rsp_uncorr <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_write <= req_write;
                        op_full  <= req_full;
                        op_size  <= req_size;
                        op_addr  <= req_addr;
                        op_wdata <= req_wdata;
                        if (rej) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end else if (req_hit) begin
                            rsp_valid <= 1'b1;
                            if (req_write) buf_data  <= mg_data;
                            else           rsp_rdata <= buf_data;
                        end else if (req_write && req_full && !buf_valid) begin
                            rsp_valid <= 1'b1;
                            buf_valid <= 1'b1;
                            buf_addr  <= req_addr[ADDR_W-1:2];
                            buf_data  <= req_wdata;
                        end
                    end
                end
                ST_DRAIN: begin
                    buf_valid <= 1'b0;
                    if (op_write && op_full) begin
                        rsp_valid <= 1'b1;
                        buf_valid <= 1'b1;
                        buf_addr  <= op_addr[ADDR_W-1:2];
                        buf_data  <= op_wdata;
                    end
                end
                ST_FETCH: ;
                ST_CHECK: begin
                    rsp_valid  <= 1'b1;
                    rsp_corr   <= dec_corr;
                    rsp_uncorr <= dec_uncorr;
                    if (op_write) begin
                        buf_valid <= 1'b1;
                        buf_addr  <= op_addr[ADDR_W-1:2];
                        buf_data  <= mg_data;
                    end else begin
                        rsp_rdata <= dec_data;
                    end
                end
            endcase
        end
    end

    // R1: every stored codeword has even overall parity
    p_code_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ((^mem_wdata) == 1'b0))
        else $error("stored codeword parity odd");

    // R5: decoding only happens the cycle after an SRAM read strobe
    p_fetch_before_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |-> $past(mem_en && !mem_we))
        else $error("check without preceding read");

    // R11: ready is low whenever the SRAM is being accessed
    p_busy_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready)
        else $error("ready during SRAM access");

    // R11: a response only follows an accepted request or a busy cycle
    p_rsp_has_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(accept) || $past(state != ST_IDLE)))
        else $error("response without request");

    // R9: correctable and uncorrectable flags never coincide, nor with reject
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!(rsp_corr && rsp_uncorr) && !(rsp_err && (rsp_corr || rsp_uncorr))))
        else $error("conflicting response flags");
endmodule

// File: tb/ecc_sram_ctrl_bench.sv
module ecc_sram_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int NWORDS = 1 << (AW - 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err, rsp_corr, rsp_uncorr;
    logic        mem_en, mem_we;
    logic [AW-3:0] mem_addr;
    logic [38:0] mem_wdata;
    logic [38:0] mem_rdata = '0;

    logic [38:0] sram [0:NWORDS-1];
    logic [31:0] exp_mem [0:NWORDS-1];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    logic        bvalid = 1'b0;
    logic [9:0]  baddr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_sram_ctrl #(.ADDR_W(AW)) u_ecc_sram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                sram[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= sram[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [38:0] enc(input logic [31:0] d);
        logic [5:0]  h;
        logic [38:0] cw;
        int k;
        h = '0;
        k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) h ^= 6'(p);
                k++;
            end
        end
        cw = {1'b0, h, d};
        cw[38] = ^cw;
        return cw;
    endfunction

    function automatic logic legal(input logic [1:0] sz, input logic [1:0] off);
        return (sz == 2'd0) || (sz == 2'd1 && !off[0]) || (sz == 2'd2 && off == 2'd0);
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [1:0] sz, input logic [1:0] off);
        logic [31:0] r;
        int n;
        r = old;
        n = 1 << sz;
        for (int j = 0; j < 4; j++) begin
            if (j >= int'(off) && j < int'(off) + n) r[8*j +: 8] = nw[8*j +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output logic co, output logic un, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_size  = sz;
        req_addr  = a;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        er = rsp_err;
        co = rsp_corr;
        un = rsp_uncorr;
    endtask

    task automatic op(input logic w, input logic [1:0] sz, input logic [9:0] word,
                      input logic [1:0] off, input logic [31:0] wd,
                      input logic ec, input logic eu, input string tag);
        logic [31:0] rd;
        logic er, co, un, ok, hit, full;
        int lat, elat;
        ok   = !w || legal(sz, off);
        hit  = bvalid && (baddr == word);
        full = w && (sz == 2'd2);
        if (!ok || hit || (full && !bvalid)) elat = 0;
        else elat = (bvalid ? 1 : 0) + (full ? 0 : 2);
        do_req(w, sz, {word, off}, wd, rd, er, co, un, lat);
        check("R7", "reject flag", 64'(er), 64'(!ok));
        check("R11", "response latency", 64'(lat), 64'(elat));
        check(tag, "correctable flag", 64'(co), 64'(ec && ok));
        check(tag, "uncorrectable flag", 64'(un), 64'(eu && ok));
        if (!w) check(tag, "read data", 64'(rd), 64'(exp_mem[word]));
        if (ok) begin
            if (w) exp_mem[word] = mrg(exp_mem[word], wd, sz, off);
            if (!hit) begin
                bvalid = w;
                baddr  = word;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [38:0] saved;
        int wc, rc;
        void'($urandom(32'h1234_5EED));
        for (int i = 0; i < NWORDS; i++) begin
            d = $urandom;
            sram[i] = enc(d);
            exp_mem[i] = d;
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "ready in reset", 64'(req_ready), 64'd1);
        check("R12", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R12", "mem_en in reset", 64'(mem_en), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R1: posted write and drain on a later request
        saved = sram[3];
        wc = wr_cnt;
        op(1'b1, 2'd2, 10'd3, 2'd0, 32'hCAFE_0001, 1'b0, 1'b0, "R2");
        repeat (5) @(negedge clk);
        check("R2", "no SRAM write while posted", 64'(wr_cnt), 64'(wc));
        check("R2", "SRAM untouched while posted", 64'(sram[3]), 64'(saved));
        op(1'b0, 2'd2, 10'd9, 2'd0, 32'h0, 1'b0, 1'b0, "R2");
        check("R2", "one drain write", 64'(wr_cnt), 64'(wc + 1));
        check("R1", "stored codeword", 64'(sram[3]), 64'(enc(32'hCAFE_0001)));

        // R3 / R4: forwarding and merging into the buffer
        op(1'b1, 2'd2, 10'd5, 2'd0, 32'h1122_3344, 1'b0, 1'b0, "R4");
        wc = wr_cnt;
        rc = rd_cnt;
        op(1'b0, 2'd0, 10'd5, 2'd3, 32'h0, 1'b0, 1'b0, "R3");
        op(1'b1, 2'd0, 10'd5, 2'd2, 32'h00AB_0000, 1'b0, 1'b0, "R4");
        op(1'b1, 2'd1, 10'd5, 2'd0, 32'h0000_CDEF, 1'b0, 1'b0, "R4");
        op(1'b0, 2'd2, 10'd5, 2'd0, 32'h0, 1'b0, 1'b0, "R4");
        check("R3", "no SRAM access on hits", 64'(wr_cnt + rd_cnt), 64'(wc + rc));

        // R5 / R6: byte write miss with a full buffer
        wc = wr_cnt;
        rc = rd_cnt;
        op(1'b1, 2'd0, 10'd12, 2'd1, 32'h0000_5A00, 1'b0, 1'b0, "R5");
        check("R5", "pre-read issued", 64'(rd_cnt), 64'(rc + 1));
        check("R5", "drain issued", 64'(wr_cnt), 64'(wc + 1));
        op(1'b0, 2'd2, 10'd12, 2'd0, 32'h0, 1'b0, 1'b0, "R6");
        op(1'b1, 2'd1, 10'd13, 2'd2, 32'h7788_0000, 1'b0, 1'b0, "R6");
        op(1'b0, 2'd0, 10'd20, 2'd1, 32'h0, 1'b0, 1'b0, "R6");
        op(1'b0, 2'd2, 10'd13, 2'd0, 32'h0, 1'b0, 1'b0, "R6");

        // R7: rejects leave buffer and SRAM alone
        op(1'b1, 2'd1, 10'd12, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
        op(1'b1, 2'd2, 10'd12, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
        op(1'b1, 2'd3, 10'd12, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
        op(1'b0, 2'd2, 10'd12, 2'd0, 32'h0, 1'b0, 1'b0, "R7");
        op(1'b1, 2'd2, 10'd7, 2'd0, 32'h0BAD_F00D, 1'b0, 1'b0, "R7");
        wc = wr_cnt;
        op(1'b1, 2'd1, 10'd7, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
        check("R7", "reject causes no drain", 64'(wr_cnt), 64'(wc));
        op(1'b0, 2'd2, 10'd7, 2'd0, 32'h0, 1'b0, 1'b0, "R7");
        op(1'b0, 2'd2, 10'd21, 2'd0, 32'h0, 1'b0, 1'b0, "R7");

        // R8: single flips in data, check and parity bits
        @(negedge clk);
        sram[30][13] = ~sram[30][13];
        sram[31][35] = ~sram[31][35];
        sram[32][38] = ~sram[32][38];
        op(1'b0, 2'd2, 10'd30, 2'd0, 32'h0, 1'b1, 1'b0, "R8");
        op(1'b0, 2'd2, 10'd31, 2'd0, 32'h0, 1'b1, 1'b0, "R8");
        op(1'b0, 2'd2, 10'd32, 2'd0, 32'h0, 1'b1, 1'b0, "R8");
        op(1'b1, 2'd1, 10'd30, 2'd2, 32'h4242_0000, 1'b1, 1'b0, "R8");
        op(1'b0, 2'd2, 10'd30, 2'd0, 32'h0, 1'b0, 1'b0, "R8");

        // R9: double flips return raw data
        @(negedge clk);
        sram[40][2]  = ~sram[40][2];
        sram[40][17] = ~sram[40][17];
        exp_mem[40]  = exp_mem[40] ^ 32'h0002_0004;
        sram[41][32] = ~sram[41][32];
        sram[41][33] = ~sram[41][33];
        op(1'b0, 2'd2, 10'd40, 2'd0, 32'h0, 1'b0, 1'b1, "R9");
        op(1'b0, 2'd2, 10'd41, 2'd0, 32'h0, 1'b0, 1'b1, "R9");

        // R10: sub-word write over an uncorrectable word still proceeds
        @(negedge clk);
        sram[50][4] = ~sram[50][4];
        sram[50][9] = ~sram[50][9];
        exp_mem[50] = exp_mem[50] ^ 32'h0000_0210;
        op(1'b1, 2'd0, 10'd50, 2'd3, 32'h9900_0000, 1'b0, 1'b1, "R10");
        op(1'b0, 2'd2, 10'd50, 2'd0, 32'h0, 1'b0, 1'b0, "R10");
        op(1'b0, 2'd2, 10'd51, 2'd0, 32'h0, 1'b0, 1'b0, "R10");
        op(1'b0, 2'd2, 10'd50, 2'd0, 32'h0, 1'b0, 1'b0, "R10");
        check("R1", "rewritten codeword", 64'(sram[50]), 64'(enc(exp_mem[50])));

        // Random mix over a few words so the buffer is hit often
        for (int n = 0; n < 400; n++) begin
            logic w;
            logic [1:0] sz, off;
            logic [9:0] word;
            logic [31:0] wd;
            w    = 1'($urandom_range(0, 1));
            sz   = 2'($urandom_range(0, 3));
            off  = 2'($urandom_range(0, 3));
            word = 10'($urandom_range(0, 7));
            wd   = $urandom;
            op(w, sz, word, off, wd, 1'b0, 1'b0,
               (bvalid && baddr == word) ? "R3" : "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule